// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating

This block sends bytes as asynchronous serial frames on a single output line. A CPU-side write port fills a one-word hold buffer. A bit-rate strobe from a baud generator outside the block paces the frames. Each frame is one low start bit, the data bits least significant first, and one high stop bit. The line rests high between frames. When a frame begins, the buffered word moves into the shift register, the block pulses an interrupt for one cycle, and the buffer is empty again for the next byte.

A mode input switches on flow control by an active-low clear-to-send input. The input passes through a synchronizer and is looked at only where a new frame could begin. Flow control therefore acts on whole frames. A frame that has started always runs to its stop bit. Further frames are held back while clear-to-send is high. A byte written during that time waits in the buffer and goes out on the first bit strobe after the line returns low. A receiver can raise its request-to-send line after every byte it takes in, and so avoid overruns.

Top module: `uart_cts_tx`

## Requirements
- R1: During and after a synchronous reset, `txd` is 1, `buf_empty` is 1, and `tx_irq` and `wr_ovw` are 0.
- R2: A frame is a start bit of 0, then DATA_W data bits with bit 0 first, then a stop bit of 1. Each bit holds `txd` for exactly one `bit_tick` interval. `txd` changes only on the clock edge that follows a cycle in which `bit_tick` is 1.
- R3: A write makes `buf_empty` 0 one cycle later. When a frame starts, `tx_irq` is 1 for that cycle, `buf_empty` returns to 1 in the same cycle, and `txd` shows the start bit in the same cycle.
- R4: A write while the buffer is full replaces the buffered byte. It raises `wr_ovw` for one cycle, in the cycle after the write, and the frame that follows carries the newest byte.
- R5: With `hs_en` = 0, `cts_n` has no effect, and a buffered byte starts on the next `bit_tick`.
- R6: With `hs_en` = 1 and `cts_n` = 1, no frame starts, and a written byte stays in the buffer (`buf_empty` = 0).
- R7: If `cts_n` rises while a frame is being sent, that frame completes with correct data and stop bit. The next byte can still be written after `tx_irq`, and it is held unsent.
- R8: After `cts_n` falls, with a byte waiting, a frame starts on the first `bit_tick` after the two-stage synchronizer has passed the low level. That is within one tick interval plus four clock cycles.
- R9: If the buffer holds a byte, and sending is allowed, at the tick that ends a stop bit, the next start bit follows at once. Consecutive frame starts are then (DATA_W+2) tick intervals apart.
- R10: `tx_irq` is never 1 for two cycles in a row. It pulses exactly once per frame sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe marking each transmit bit boundary |
| hs_en | input | 1 | 1 enables clear-to-send flow control |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the hold buffer |
| wr_data | input | DATA_W | Byte to send |
| txd | output | 1 | Serial line, idles high |
| tx_irq | output | 1 | One-cycle pulse when a byte leaves the buffer |
| buf_empty | output | 1 | 1 when the hold buffer can take a byte |
| wr_ovw | output | 1 | One-cycle pulse after a write replaced an unsent byte |

## Verification
A wrong bit counter or shift state shows at `txd` within one frame: a misplaced bit, a stop bit that is 0, or a frame that is too long or too short. The capture monitor sees each of these as a data mismatch or a stop error no later than ten tick intervals after the start. A wrong launch decision breaks the spacing between starts. It shows as a frame that starts while clear-to-send is high, or as a delay longer than one tick after the line falls, and it appears within the hold windows the bench waits through. A stale buffer flag shows one cycle after a write or a frame start, on `buf_empty` or `wr_ovw`.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tx_holdbuf.sv
module tx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic              ovw_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
      ovw_pulse <= 1'b0;
    end else begin
      ovw_pulse <= wr_en && hold_full && !take;
      if (wr_en) begin
        hold_data <= wr_data;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end

  // R3: a write always leaves the buffer holding data
  p_write_fills_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hold_full);

  // R4: an overwrite report implies the buffer still holds a byte
  p_ovw_full_r4: assert property (@(posedge clk) disable iff (rst)
    ovw_pulse |-> hold_full);
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import uart_cts_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              send_ok,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              idle,
  output logic              txd,
  output logic              irq
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  tx_state_t         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    take = bit_tick && hold_full && send_ok &&
           ((state == TX_IDLE) || (state == TX_STOP));
  end

  assign idle = (state == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      shreg <= '0;
      cnt   <= '0;
      txd   <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= take;
      if (bit_tick) begin
        case (state)
          TX_IDLE, TX_STOP: begin
            if (take) begin
              shreg <= hold_data;
              txd   <= 1'b0;
              state <= TX_START;
            end else begin
              txd   <= 1'b1;
              state <= TX_IDLE;
            end
          end
          TX_START: begin
            txd   <= shreg[0];
            shreg <= {1'b0, shreg[DATA_W-1:1]};
            cnt   <= '0;
            state <= TX_DATA;
          end
          TX_DATA: begin
            if (cnt == LAST_CNT) begin
              txd   <= 1'b1;
              state <= TX_STOP;
            end else begin
              txd   <= shreg[0];
              shreg <= {1'b0, shreg[DATA_W-1:1]};
              cnt   <= cnt + 1'b1;
            end
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

  // R10: interrupt lasts a single cycle
  p_irq_single_r10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R2: the line only moves on a bit boundary
  p_line_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(txd));

  // R2: the stop bit is high
  p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state == TX_STOP) |-> txd);

  // R1: the idle line is high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE) |-> txd);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              hs_en,
  input  logic              cts_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_irq,
  output logic              buf_empty,
  output logic              wr_ovw
);
  logic              cts_s;
  logic              send_ok;
  logic              take;
  logic              idle;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  cts_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cts_n),
    .dout (cts_s)
  );

  assign send_ok = !hs_en || !cts_s;

  tx_holdbuf #(.DATA_W(DATA_W)) i_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full),
    .ovw_pulse (wr_ovw)
  );

  tx_framer #(.DATA_W(DATA_W)) i_framer (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .send_ok   (send_ok),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .idle      (idle),
    .txd       (txd),
    .irq       (tx_irq)
  );

  assign buf_empty = !hold_full;

  // R3: a frame only starts from a full buffer
  p_launch_from_full_r3: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> $past(hold_full));

  // R6: an idle line with clear-to-send high starts nothing
  p_hs_block_r6: assert property (@(posedge clk) disable iff (rst)
    (hs_en && cts_s && idle) |=> !tx_irq);
endmodule

// File: tb/test_uart_cts_tx.sv
module test_uart_cts_tx;
  localparam int DW = 8;
  localparam int TICK_DIV = 8;
  localparam int FRAME_CYC = (DW + 2) * TICK_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0;
  logic hs_en = 1'b0;
  logic cts_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic txd, tx_irq, buf_empty, wr_ovw;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  longint cyc = 0;

  logic [DW-1:0] cap_data[$];
  longint cap_t[$];
  int stop_errs = 0;
  int irq_count = 0;
  int irq_long = 0;

  uart_cts_tx #(.DATA_W(DW), .SYNC_STAGES(2)) i_uart_cts_tx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .hs_en(hs_en), .cts_n(cts_n),
    .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .tx_irq(tx_irq),
    .buf_empty(buf_empty), .wr_ovw(wr_ovw)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin : tick_gen
    int tc = 0;
    forever begin
      @(negedge clk);
      bit_tick = (tc == TICK_DIV - 1);
      tc = (tc == TICK_DIV - 1) ? 0 : tc + 1;
    end
  end

  // frame capture at the ports
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        logic [DW-1:0] b;
        longint t0;
        t0 = cyc;
        for (int i = 0; i < DW; i++) begin
          repeat (TICK_DIV) @(negedge clk);
          b[i] = txd;
        end
        repeat (TICK_DIV) @(negedge clk);
        if (txd !== 1'b1) stop_errs++;
        cap_data.push_back(b);
        cap_t.push_back(t0);
      end
    end
  end

  initial begin : irq_mon
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (tx_irq) irq_count++;
        if (tx_irq && prev) irq_long++;
        prev = tx_irq;
      end
    end
  end

  function automatic bit frame_ok(logic [DW-1:0] got, logic [DW-1:0] exp);
    return got === exp;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_byte(logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frames(int n, string req);
    int t = 0;
    while (cap_data.size() < n && t < 4 * FRAME_CYC) begin
      @(negedge clk);
      t++;
    end
    chk(cap_data.size() >= n, req, cap_data.size(), n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] exp_q[$];
    int base;
    logic [DW-1:0] a, b;
    longint trel;
    void'($urandom(32'd2024));

    repeat (5) @(negedge clk);
    // R1 reset values
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(buf_empty === 1'b1, "R1 buf_empty", buf_empty, 1);
    chk(tx_irq === 1'b0 && wr_ovw === 1'b0, "R1 irq/ovw", tx_irq, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && buf_empty === 1'b1, "R1 after reset", txd, 1);

    // Phase A: handshake off, cts_n random, back-to-back (R2 R5 R9)
    hs_en = 1'b0;
    base = cap_data.size();
    for (int i = 0; i < 12; i++) begin
      logic [DW-1:0] d;
      d = DW'($urandom);
      while (!buf_empty) @(negedge clk);
      cts_n = $urandom_range(0, 1);
      write_byte(d);
      chk(buf_empty === 1'b0, "R3 write fills", buf_empty, 0);
      exp_q.push_back(d);
    end
    wait_frames(base + 12, "R5 frames sent with handshake off");
    for (int i = 0; i < 12; i++) begin
      chk(frame_ok(cap_data[base+i], exp_q[i]), "R2 frame data",
          cap_data[base+i], exp_q[i]);
      if (i > 0)
        chk(cap_t[base+i] - cap_t[base+i-1] == FRAME_CYC, "R9 back-to-back spacing",
            cap_t[base+i] - cap_t[base+i-1], FRAME_CYC);
    end
    chk(stop_errs == 0, "R2 stop bits", stop_errs, 0);
    exp_q.delete();

    // Phase B: handshake on, cts low, random gaps (R2)
    hs_en = 1'b1;
    cts_n = 1'b0;
    base = cap_data.size();
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] d;
      d = DW'($urandom);
      while (!buf_empty) @(negedge clk);
      repeat ($urandom_range(0, 200)) @(negedge clk);
      write_byte(d);
      exp_q.push_back(d);
    end
    wait_frames(base + 6, "R2 frames with gaps");
    for (int i = 0; i < 6; i++)
      chk(frame_ok(cap_data[base+i], exp_q[i]), "R2 gapped frame data",
          cap_data[base+i], exp_q[i]);
    exp_q.delete();
    repeat (2 * FRAME_CYC) @(negedge clk);

    // Phase C: held by cts, overwrite, resume (R6 R4 R8)
    cts_n = 1'b1;
    repeat (5) @(negedge clk);
    base = cap_data.size();
    a = 8'hA5;
    b = 8'h3C;
    write_byte(a);
    chk(wr_ovw === 1'b0, "R4 no ovw on first write", wr_ovw, 0);
    write_byte(b);
    chk(wr_ovw === 1'b1, "R4 ovw pulse", wr_ovw, 1);
    @(negedge clk);
    chk(wr_ovw === 1'b0, "R4 ovw single cycle", wr_ovw, 0);
    repeat (30 * TICK_DIV) @(negedge clk);
    chk(cap_data.size() == base, "R6 no frame while cts high", cap_data.size(), base);
    chk(buf_empty === 1'b0, "R6 byte held", buf_empty, 0);
    chk(txd === 1'b1, "R6 line idle", txd, 1);
    cts_n = 1'b0;
    trel = cyc;
    wait_frames(base + 1, "R8 resume after cts low");
    chk(cap_data[base] === b, "R4 newest byte sent", cap_data[base], b);
    chk(cap_t[base] - trel <= TICK_DIV + 4, "R8 resume delay",
        cap_t[base] - trel, TICK_DIV + 4);

    // Phase D: cts rises mid-frame (R3 R7 R8)
    repeat (2 * FRAME_CYC) @(negedge clk);
    base = cap_data.size();
    a = 8'h81;
    b = 8'h7E;
    write_byte(a);
    while (!tx_irq) @(negedge clk);
    chk(txd === 1'b0, "R3 start bit with irq", txd, 0);
    chk(buf_empty === 1'b1, "R3 buffer empty with irq", buf_empty, 1);
    write_byte(b);
    repeat (3 * TICK_DIV) @(negedge clk);
    cts_n = 1'b1;
    wait_frames(base + 1, "R7 current frame finishes");
    chk(cap_data[base] === a, "R7 frame data intact", cap_data[base], a);
    chk(stop_errs == 0, "R7 stop bit intact", stop_errs, 0);
    repeat (20 * TICK_DIV) @(negedge clk);
    chk(cap_data.size() == base + 1, "R7 next frame held", cap_data.size(), base + 1);
    chk(buf_empty === 1'b0, "R7 next byte buffered", buf_empty, 0);
    cts_n = 1'b0;
    trel = cyc;
    wait_frames(base + 2, "R8 held byte sent");
    chk(cap_data[base+1] === b, "R8 held byte data", cap_data[base+1], b);
    chk(cap_t[base+1] - trel <= TICK_DIV + 4, "R8 resume delay mid-frame case",
        cap_t[base+1] - trel, TICK_DIV + 4);

    // Phase E: handshake off, cts high ignored (R5)
    repeat (2 * FRAME_CYC) @(negedge clk);
    hs_en = 1'b0;
    cts_n = 1'b1;
    base = cap_data.size();
    trel = cyc;
    write_byte(8'h5A);
    wait_frames(base + 1, "R5 send with cts high");
    chk(cap_data[base] === 8'h5A, "R5 data", cap_data[base], 8'h5A);
    chk(cap_t[base] - trel <= TICK_DIV + 2, "R5 start on next tick",
        cap_t[base] - trel, TICK_DIV + 2);

    repeat (2 * FRAME_CYC) @(negedge clk);
    // R10 interrupt checks
    chk(irq_long == 0, "R10 irq single cycle", irq_long, 0);
    chk(irq_count == cap_data.size(), "R10 one irq per frame", irq_count, cap_data.size());

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule